// File: doc/BRIEF.md
# Key Trial Engine: Subkey Expansion and Block Decrypt

The block checks one candidate key against a known ciphertext/plaintext pair. A start pulse latches a 64-bit candidate key, a 64-bit ciphertext and a 64-bit expected plaintext. The engine first expands the key into a table of 26 32-bit subkeys. The table begins from a fixed constant vector, and the key is mixed into it over 78 serial steps, one step per clock. Each step uses a data-dependent 32-bit rotation.

After the expansion, the engine runs twelve inverse double half-rounds over the ciphertext. These take subkeys from the top of the table downwards. A final whitening subtraction follows, and then the recovered block is compared with the expected plaintext. A one-cycle done pulse reports the end of the run, together with a match flag. A search loop outside the block feeds candidate keys and waits for done between them.

Top module: `key_trial_core`

## Requirements
- R1: While rst_ni is low, and after reset is released with no start, busy_o, done_o and match_o are all 0.
- R2: A start_i pulse sampled while busy_o is 0 starts a run. busy_o is 1 from the next cycle until done_o.
- R3: A start_i pulse sampled while busy_o is 1 is ignored. The run in progress finishes at its original time with the result of its original inputs, and no extra done_o pulse follows.
- R4: Before mixing, the subkey table holds T[k] = 0xB7E15163 + k*0x9E3779B9 mod 2^32 for k = 0..25. The key words are L[0] = key_i[31:0] and L[1] = key_i[63:32], and the mix registers A and B start at 0.
- R5: Mixing runs 78 steps with table index i (mod 26) and key index j (mod 2), both starting at 0. Each step computes A = rotl(T[i]+A+B, 3) and writes it to T[i]. It then computes B = rotl(B+L[j]+A, (A+B) mod 32) with the new A and writes it to L[j].
- R6: Decrypt loads A = ct_i[31:0] and B = ct_i[63:32]. For r = 12 down to 1 it computes B = rotr(B-T[2r+1], A mod 32) xor A, then A = rotr(A-T[2r], B mod 32) xor B. It finishes with B = B-T[1] and A = A-T[0].
- R7: done_o is a one-cycle pulse 91 cycles after the start edge (78 mix plus 13 decrypt cycles). busy_o falls in that same cycle.
- R8: match_o is 1 with done_o exactly when {B,A} equals pt_i (B compared with pt_i[63:32], A with pt_i[31:0]). A difference in either word alone gives 0.
- R9: match_o holds its value after done_o and is cleared on the edge that accepts the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse; latches key_i, ct_i, pt_i |
| key_i | input | 64 | Candidate key, low word is L[0] |
| ct_i | input | 64 | Ciphertext, low word is A |
| pt_i | input | 64 | Expected plaintext, low word is A |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| match_o | output | 1 | Recovered block equals expected plaintext |

## Verification
busy_o is due one cycle after the start edge. done_o and the verdict on match_o are due exactly 91 cycles after that edge. The driver notes the cycle count at the start edge and pushes the expected verdict into a queue. The monitor samples on falling edges, pops an entry when done_o is seen, and checks that the cycle count equals the noted value plus 91. Expected verdicts come from a bench model of the expansion together with encryption and decryption functions.

// File: rtl/key_trial_pkg.sv
package key_trial_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ROT_W  = $clog2(WORD_W);
  localparam logic [WORD_W-1:0] MAGIC_BASE = 32'hB7E15163;
  localparam logic [WORD_W-1:0] MAGIC_STEP = 32'h9E3779B9;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MIX  = 2'd1,
    ST_DEC  = 2'd2
  } phase_e;

  // Hardwired initial table entry
  function automatic word_t seed_word(input int unsigned idx);
    return MAGIC_BASE + word_t'(idx) * MAGIC_STEP;
  endfunction
endpackage

// File: rtl/kt_rotator.sv
module kt_rotator
  import key_trial_pkg::*;
#(
  parameter bit ROT_LEFT = 1'b1
) (
  input  word_t            data_i,
  input  logic [ROT_W-1:0] amt_i,
  output word_t            data_o
);
  logic [2*WORD_W-1:0] dbl;

  generate
    if (ROT_LEFT) begin : g_left
      always_comb begin
        dbl    = {data_i, data_i} << amt_i;
        data_o = dbl[2*WORD_W-1:WORD_W];
      end
    end else begin : g_right
      always_comb begin
        dbl    = {data_i, data_i} >> amt_i;
        data_o = dbl[WORD_W-1:0];
      end
    end
  endgenerate
endmodule

// File: rtl/kt_subkey_tbl.sv
module kt_subkey_tbl
  import key_trial_pkg::*;
#(
  parameter int unsigned DEPTH = 26,
  localparam int unsigned AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          seed_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  word_t         wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  output word_t         rdata_a_o,
  output word_t         rdata_b_o
);
  word_t mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= seed_word(k);
    end else if (seed_i) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= seed_word(k);
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];

  assert_waddr_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (32'(waddr_i) < DEPTH));
endmodule

// File: rtl/kt_sequencer.sv
module kt_sequencer
  import key_trial_pkg::*;
#(
  parameter int unsigned DEPTH     = 26,
  parameter int unsigned KEY_WORDS = 2,
  parameter int unsigned ROUNDS    = 12,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned KJ_W   = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1,
  localparam int unsigned RND_W  = $clog2(ROUNDS + 1),
  localparam int unsigned MIX_N  = 3 * ((DEPTH > KEY_WORDS) ? DEPTH : KEY_WORDS),
  localparam int unsigned STEP_W = $clog2(MIX_N + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  output phase_e           phase_o,
  output logic             accept_o,
  output logic             mix_last_o,
  output logic             fin_o,
  output logic [IDX_W-1:0] tidx_o,
  output logic [KJ_W-1:0]  kidx_o,
  output logic [RND_W-1:0] rnd_o
);
  phase_e            phase_q;
  logic [STEP_W-1:0] step_q;
  logic [IDX_W-1:0]  tidx_q;
  logic [KJ_W-1:0]   kidx_q;
  logic [RND_W-1:0]  rnd_q;

  assign accept_o   = start_i && (phase_q == ST_IDLE);
  assign mix_last_o = (phase_q == ST_MIX) && (step_q == STEP_W'(MIX_N - 1));
  assign fin_o      = (phase_q == ST_DEC) && (rnd_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= ST_IDLE;
      step_q  <= '0;
      tidx_q  <= '0;
      kidx_q  <= '0;
      rnd_q   <= '0;
    end else begin
      unique case (phase_q)
        ST_IDLE: if (accept_o) begin
          phase_q <= ST_MIX;
          step_q  <= '0;
          tidx_q  <= '0;
          kidx_q  <= '0;
        end
        ST_MIX: begin
          step_q <= step_q + 1'b1;
          tidx_q <= (tidx_q == IDX_W'(DEPTH - 1)) ? '0 : tidx_q + 1'b1;
          kidx_q <= (kidx_q == KJ_W'(KEY_WORDS - 1)) ? '0 : kidx_q + 1'b1;
          if (mix_last_o) begin
            phase_q <= ST_DEC;
            rnd_q   <= RND_W'(ROUNDS);
          end
        end
        ST_DEC: begin
          if (fin_o) phase_q <= ST_IDLE;
          else       rnd_q   <= rnd_q - 1'b1;
        end
        default: phase_q <= ST_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign tidx_o  = tidx_q;
  assign kidx_o  = kidx_q;
  assign rnd_o   = rnd_q;

  assert_step_advances_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_MIX && !mix_last_o) |=> (phase_q == ST_MIX && step_q == $past(step_q) + 1'b1));

  assert_busy_start_ignored_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_MIX && step_q != '0 && !mix_last_o && start_i) |=> (step_q != '0));

  assert_tidx_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tidx_q) < DEPTH);

  assert_rounds_descend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == ST_DEC && !fin_o) |=> (rnd_q == $past(rnd_q) - 1'b1));
endmodule

// File: rtl/key_trial_core.sv
module key_trial_core
  import key_trial_pkg::*;
#(
  parameter int unsigned KEY_WORDS = 2,
  parameter int unsigned ROUNDS    = 12,
  localparam int unsigned DEPTH  = 2 * ROUNDS + 2,
  localparam int unsigned IDX_W  = $clog2(DEPTH),
  localparam int unsigned KJ_W   = (KEY_WORDS > 1) ? $clog2(KEY_WORDS) : 1,
  localparam int unsigned RND_W  = $clog2(ROUNDS + 1),
  localparam int unsigned KEY_W  = KEY_WORDS * WORD_W,
  localparam int unsigned BLK_W  = 2 * WORD_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic [BLK_W-1:0] ct_i,
  input  logic [BLK_W-1:0] pt_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             match_o
);
  phase_e           phase;
  logic             accept, mix_last, fin;
  logic [IDX_W-1:0] tidx;
  logic [KJ_W-1:0]  kidx;
  logic [RND_W-1:0] rnd;

  kt_sequencer #(
    .DEPTH(DEPTH), .KEY_WORDS(KEY_WORDS), .ROUNDS(ROUNDS)
  ) u_seq (
    .clk_i, .rst_ni, .start_i,
    .phase_o(phase), .accept_o(accept), .mix_last_o(mix_last), .fin_o(fin),
    .tidx_o(tidx), .kidx_o(kidx), .rnd_o(rnd)
  );

  word_t a_q, b_q;
  word_t lk_q [KEY_WORDS];
  logic [BLK_W-1:0] ct_q, pt_q;

  logic             mix_en;
  logic [IDX_W-1:0] raddr_a, raddr_b;
  word_t            tbl_a, tbl_b;
  word_t            a_mix, b_mix, a_dec, b_dec, a_fin, b_fin;

  assign mix_en  = (phase == ST_MIX);
  // Decrypt reads the odd/even pair of the current round, top first
  assign raddr_a = mix_en ? tidx : {rnd, 1'b1};
  assign raddr_b = {rnd, 1'b0};

  kt_subkey_tbl #(.DEPTH(DEPTH)) u_tbl (
    .clk_i, .rst_ni,
    .seed_i(accept), .we_i(mix_en), .waddr_i(tidx), .wdata_i(a_mix),
    .raddr_a_i(raddr_a), .raddr_b_i(raddr_b),
    .rdata_a_o(tbl_a), .rdata_b_o(tbl_b)
  );

  // Mixing step
  word_t            sum_a, sum_b, b_sel;
  logic [ROT_W-1:0] b_amt;
  assign sum_a = tbl_a + a_q + b_q;
  assign b_sel = lk_q[kidx];

  kt_rotator #(.ROT_LEFT(1'b1)) u_rot_a (
    .data_i(sum_a), .amt_i(ROT_W'(3)), .data_o(a_mix)
  );

  assign sum_b = b_q + b_sel + a_mix;
  assign b_amt = ROT_W'(a_mix + b_q);

  kt_rotator #(.ROT_LEFT(1'b1)) u_rot_b (
    .data_i(sum_b), .amt_i(b_amt), .data_o(b_mix)
  );

  // Inverse double half-round
  word_t db_sub, da_sub, db_rot, da_rot;
  assign db_sub = b_q - tbl_a;
  kt_rotator #(.ROT_LEFT(1'b0)) u_rot_db (
    .data_i(db_sub), .amt_i(a_q[ROT_W-1:0]), .data_o(db_rot)
  );
  assign b_dec  = db_rot ^ a_q;

  assign da_sub = a_q - tbl_b;
  kt_rotator #(.ROT_LEFT(1'b0)) u_rot_da (
    .data_i(da_sub), .amt_i(b_dec[ROT_W-1:0]), .data_o(da_rot)
  );
  assign a_dec  = da_rot ^ b_dec;

  assign b_fin = b_q - tbl_a;
  assign a_fin = a_q - tbl_b;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q     <= '0;
      b_q     <= '0;
      ct_q    <= '0;
      pt_q    <= '0;
      done_o  <= 1'b0;
      match_o <= 1'b0;
      for (int k = 0; k < KEY_WORDS; k++) lk_q[k] <= '0;
    end else begin
      done_o <= 1'b0;
      if (accept) begin
        a_q     <= '0;
        b_q     <= '0;
        ct_q    <= ct_i;
        pt_q    <= pt_i;
        match_o <= 1'b0;
        for (int k = 0; k < KEY_WORDS; k++) lk_q[k] <= key_i[k*WORD_W +: WORD_W];
      end else if (mix_en) begin
        a_q        <= mix_last ? ct_q[WORD_W-1:0]     : a_mix;
        b_q        <= mix_last ? ct_q[BLK_W-1:WORD_W] : b_mix;
        lk_q[kidx] <= b_mix;
      end else if (phase == ST_DEC) begin
        if (fin) begin
          a_q     <= a_fin;
          b_q     <= b_fin;
          done_o  <= 1'b1;
          match_o <= ({b_fin, a_fin} == pt_q);
        end else begin
          a_q <= a_dec;
          b_q <= b_dec;
        end
      end
    end
  end

  assign busy_o = (phase != ST_IDLE);

  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_no_match_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !match_o);

  assert_busy_from_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(start_i));

  assert_match_stable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !done_o && !$past(start_i)) |-> $stable(match_o));
endmodule

// File: tb/key_trial_core_tb_top.sv
module key_trial_core_tb_top;
  localparam int unsigned TBL = 26;
  localparam int unsigned LAT = 3 * TBL + 12 + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [63:0] key = '0, ct = '0, pt = '0;
  logic        busy, done, match;

  always #4 clk = ~clk;

  key_trial_core dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .key_i(key), .ct_i(ct), .pt_i(pt),
    .busy_o(busy), .done_o(done), .match_o(match)
  );

  int unsigned n_chk = 0, n_fail = 0, cyc = 0, n_done = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Behavioural model
  logic [31:0] ms [TBL];

  function automatic logic [31:0] rl(input logic [31:0] x, input logic [4:0] s);
    logic [63:0] t;
    t = {x, x} << s;
    return t[63:32];
  endfunction
  function automatic logic [31:0] rr(input logic [31:0] x, input logic [4:0] s);
    logic [63:0] t;
    t = {x, x} >> s;
    return t[31:0];
  endfunction

  task automatic m_expand(input logic [63:0] k);
    logic [31:0] l [2];
    logic [31:0] a, b;
    int i, j;
    ms[0] = 32'hB7E15163;
    for (int n = 1; n < TBL; n++) ms[n] = ms[n-1] + 32'h9E3779B9;
    l[0] = k[31:0]; l[1] = k[63:32];
    a = 0; b = 0; i = 0; j = 0;
    for (int n = 0; n < 3 * TBL; n++) begin
      a = rl(ms[i] + a + b, 5'd3);
      ms[i] = a;
      b = rl(b + l[j] + a, 5'(a + b));
      l[j] = b;
      i = (i + 1) % TBL;
      j = (j + 1) % 2;
    end
  endtask

  function automatic logic [63:0] m_enc(input logic [63:0] p);
    logic [31:0] a, b;
    a = p[31:0] + ms[0];
    b = p[63:32] + ms[1];
    for (int r = 1; r <= 12; r++) begin
      a = rl(a ^ b, b[4:0]) + ms[2*r];
      b = rl(b ^ a, a[4:0]) + ms[2*r+1];
    end
    return {b, a};
  endfunction

  function automatic logic [63:0] m_dec(input logic [63:0] c);
    logic [31:0] a, b;
    a = c[31:0]; b = c[63:32];
    for (int r = 12; r >= 1; r--) begin
      b = rr(b - ms[2*r+1], a[4:0]) ^ a;
      a = rr(a - ms[2*r], b[4:0]) ^ b;
    end
    return {b - ms[1], a - ms[0]};
  endfunction

  // Scoreboard
  typedef struct { bit exp_m; int unsigned t0; string tag; } item_t;
  item_t sb_q[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      item_t it;
      n_done++;
      if (sb_q.size() == 0) begin
        check(1'b0, "R3 unexpected done", 1, 0);
      end else begin
        it = sb_q.pop_front();
        check(match == it.exp_m, {it.tag, " match"}, match, it.exp_m);
        check(cyc == it.t0 + LAT, "R7 done latency", cyc - it.t0, LAT);
        check(!busy, "R7 busy low at done", busy, 0);
        @(negedge clk);
        check(!done, "R7 done one cycle", done, 0);
      end
    end
  end

  task automatic pulse_start(output int unsigned t0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    t0 = cyc;
  endtask

  task automatic run_case(input logic [63:0] k, input logic [63:0] c,
                          input logic [63:0] p, input bit exp_m, input string tag);
    item_t it;
    int unsigned t0, d0;
    key = k; ct = c; pt = p;
    d0 = n_done;
    it.exp_m = exp_m; it.tag = tag;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    it.t0 = cyc;
    sb_q.push_back(it);
    check(busy, "R2 busy after start", busy, 1);
    check(!match, "R9 match cleared on start", match, 0);
    t0 = cyc;
    while (n_done == d0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    logic [63:0] k, p, c;
    int unsigned t0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !match, "R1 in reset", {busy, done, match}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(!busy && !done && !match, "R1 after reset", {busy, done, match}, 0);

    // Known pair: encrypt a fixed plaintext with the model (R4 R5 R6 R8)
    k = 64'h0123456789ABCDEF;
    m_expand(k);
    p = 64'h0;
    c = m_enc(p);
    run_case(k, c, p, 1'b1, "R4 R6 known pair");

    // Zero key, decrypt-derived plaintext
    k = 64'h0;
    m_expand(k);
    c = 64'hFEDCBA9876543210;
    run_case(k, c, m_dec(c), 1'b1, "R5 zero key");

    // Random keys
    for (int n = 0; n < 4; n++) begin
      k = {$urandom, $urandom};
      p = {$urandom, $urandom};
      m_expand(k);
      c = m_enc(p);
      run_case(k, c, p, 1'b1, "R5 R6 random key");
    end

    // One word wrong at a time (R8)
    k = {$urandom, $urandom};
    p = {$urandom, $urandom};
    m_expand(k);
    c = m_enc(p);
    run_case(k, c, p ^ 64'h1, 1'b0, "R8 low word differs");
    run_case(k, c, p ^ (64'h1 << 40), 1'b0, "R8 high word differs");

    // Match holds after done (R9)
    run_case(k, c, p, 1'b1, "R8 exact");
    repeat (20) @(negedge clk);
    check(match, "R9 match held", match, 1);

    // Start while busy is ignored (R3)
    begin
      item_t it;
      int unsigned d0;
      d0 = n_done;
      key = k; ct = c; pt = p;
      it.exp_m = 1'b1; it.tag = "R3 first run kept";
      pulse_start(t0);
      it.t0 = t0;
      sb_q.push_back(it);
      repeat (10) @(negedge clk);
      key = ~k; pt = ~p;
      pulse_start(t0);
      key = '0; ct = '0; pt = '0;
      while (n_done == d0) @(negedge clk);
      repeat (120) @(negedge clk);
      check(n_done == d0 + 1, "R3 single done", n_done - d0, 1);
      check(!busy, "R3 no second run", busy, 0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule